// File: doc/BRIEF.md
# Receive Frame Queue with Clear-to-Advance Window

This block buffers frames received by a CAN-style controller and shows only the oldest one to software. That frame appears in a fixed four-word register window. A frame-available flag is high while a valid frame sits in the window.

Software retires a frame by writing one to that flag. The write removes the frame from the queue. Over several cycles, the engine then copies the next stored frame into the window and raises the flag again. The correct handling order is:

1. Read the window. Reading the control word locks it.
2. Clear the flag.
3. Read the free-running timer, which releases the lock and lets the next frame in.

If software clears the flag before it reads the window, the flag and the frame no longer belong together.

Frames arrive as one beat on a valid/data input. The queue holds six frames, counting the one in the window. The block raises a warning flag when occupancy climbs to five. It raises an overflow flag when a frame arrives to a full queue, and that frame is dropped. One interrupt output combines the three flags with a mask register.

Top module: `rxq_window`

## Requirements
- R1: After reset the following all read 0 and `irq` is low:
  - the flag word at offset 4
  - the mask at offset 5
  - every window word at offsets 0 to 3
- R2: The window shows the oldest unretired frame:
  - offset 0 is the control word, offset 1 the identifier, offset 2 data word 0 and offset 3 data word 1.
  - A read raised on one clock edge returns its data on `reg_rdata` after that edge.
  - Window words read 0 while no frame is present.
  - Offset 7 reads 0.
- R3: Bit 5 of the flag word (frame available) is 1 exactly while the window holds a valid frame. Flag-word bits 4:0 and 31:8 read 0.
- R4: Writing 1 to flag bit 5 while it is set retires the window frame. Writing 0 to it, writing other bits, or writing 1 while it is clear changes nothing.
- R5: After a retire, with the window unlocked and frames still queued, the flag stays low and becomes 1 exactly LOAD_CYC+1 clock edges after the edge that took the write.
- R6: A retire that empties the queue leaves the flag low. A frame then arriving into the empty queue sets the flag LOAD_CYC+1 edges after its arrival edge.
- R7: Frames leave the window in arrival order.
- R8: Lock and release:
  - A read of offset 0 locks the window. While it is locked, no new frame is loaded.
  - A read of offset 6 releases the lock. A load then completes LOAD_CYC+1 edges after that read.
- R9: Offset 6 returns a free-running 16-bit timer that advances by one every clock.
- R10: The queue holds DEPTH (6) frames, including the one in the window. An arrival to a full queue with no retire in the same cycle is discarded and sets overflow, flag bit 7.
- R11: The warning flag, bit 6, sets when an accepted arrival without a same-cycle retire raises occupancy from WARN_LVL-1 (4) to WARN_LVL (5).
- R12: Warning and overflow are write-one-to-clear. A set and a clear in the same cycle leave the flag set.
- R13: Offset 5 stores a 32-bit mask that reads back as written. `irq` is the OR over flag bits 7:5, each ANDed with the same mask bit.
- R14: An arrival and a retire in the same cycle are both honoured, even when the queue is full. No frame is lost or duplicated, and overflow stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Arriving frame strobe |
| in_ctrl | input | 32 | Arriving control/status word |
| in_id | input | 32 | Arriving identifier word |
| in_d0 | input | 32 | Arriving data word 0 |
| in_d1 | input | 32 | Arriving data word 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked flag interrupt |

## Verification
Two situations are hard to reach from the ports:
- A retire while the queue is full, landing on the same edge as a new arrival.
- A retire issued under the window lock, followed by the load that waits for the timer read.

To reach the first, the bench fills the queue with back-to-back arrivals. It then drives an arrival and a flag-clear write in one cycle, and drains the queue to prove that the order holds and that no frame was dropped or repeated. To reach the second, the bench follows the full read, clear, timer-read sequence and measures the gap between the timer read and the rise of `irq`. A behavioural queue model shadows every clock to catch timing slips elsewhere.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int WORD_W = 32;
  localparam int ADR_W  = 3;

  localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADR_W-1:0] ADR_ID    = 3'd1;
  localparam logic [ADR_W-1:0] ADR_D0    = 3'd2;
  localparam logic [ADR_W-1:0] ADR_D1    = 3'd3;
  localparam logic [ADR_W-1:0] ADR_FLAGS = 3'd4;
  localparam logic [ADR_W-1:0] ADR_MASK  = 3'd5;
  localparam logic [ADR_W-1:0] ADR_TIMER = 3'd6;

  localparam int FLG_AVAIL = 5;
  localparam int FLG_WARN  = 6;
  localparam int FLG_OVF   = 7;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] d0;
    logic [WORD_W-1:0] d1;
  } rxq_frame_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store import rxq_pkg::*; #(
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push_valid,
  input  rxq_frame_t push_frame,
  input  logic       pop,
  output rxq_frame_t head_q,
  output logic       nonempty,
  output logic       warn_set,
  output logic       ovf_set
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_PREW = CNT_W'(WARN_LVL - 1);

  rxq_frame_t        mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              accept;

  assign accept   = push_valid && ((count != CNT_FULL) || pop);
  assign ovf_set  = push_valid && !accept;
  assign warn_set = accept && !pop && (count == CNT_PREW);
  assign nonempty = (count != '0);

  // storage: no reset, registered read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_frame;
    head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      if (accept && !pop)      count <= count + 1'b1;
      else if (pop && !accept) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push_valid && count == CNT_FULL && !pop) |=> $stable(count)); // R10
  AST_SAME_CYCLE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (push_valid && pop) |=> $stable(count)); // R14
  AST_POP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0)); // R4
endmodule

// File: rtl/rxq_loader.sv
module rxq_loader import rxq_pkg::*; #(
  parameter int LOAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  rxq_frame_t head_q,
  input  logic       nonempty,
  input  logic       pop,
  input  logic       lock_set,
  input  logic       lock_clr,
  output rxq_frame_t win_frame,
  output logic       win_valid
);
  localparam int CW = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
  localparam logic [CW-1:0] CNT_START = CW'(LOAD_CYC - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      locked    <= 1'b0;
      win_valid <= 1'b0;
      win_frame <= '0;
    end else begin
      if (lock_set)      locked <= 1'b1;
      else if (lock_clr) locked <= 1'b0;

      if (busy) begin
        if (cnt == '0) begin
          win_frame <= head_q;
          win_valid <= 1'b1;
          busy      <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (pop) begin
        win_valid <= 1'b0;
      end else if (!win_valid && nonempty && !locked) begin
        busy <= 1'b1;
        cnt  <= CNT_START;
      end
    end
  end

  AST_RETIRE_EMPTIES_WINDOW: assert property (@(posedge clk) disable iff (rst)
    pop |=> !win_valid); // R4
  AST_LOCK_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (locked && !busy && !lock_clr) |=> !busy); // R8
  AST_LOADING_HIDES_WINDOW: assert property (@(posedge clk) disable iff (rst)
    busy |-> !win_valid); // R5
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(win_valid) |-> $past(busy)); // R5
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs import rxq_pkg::*; #(
  parameter int TIMER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  rxq_frame_t        win_frame,
  input  logic              win_valid,
  input  logic              warn_set,
  input  logic              ovf_set,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  output logic              pop,
  output logic              lock_set,
  output logic              lock_clr
);
  logic               warn, ovf;
  logic [WORD_W-1:0]  mask;
  logic [TIMER_W-1:0] timer;
  logic [WORD_W-1:0]  flag_word;
  logic               flag_wr;

  always_comb begin
    flag_word            = '0;
    flag_word[FLG_AVAIL] = win_valid;
    flag_word[FLG_WARN]  = warn;
    flag_word[FLG_OVF]   = ovf;
  end

  assign flag_wr  = reg_wr && (reg_addr == ADR_FLAGS);
  assign pop      = flag_wr && reg_wdata[FLG_AVAIL] && win_valid;
  assign lock_set = reg_rd && (reg_addr == ADR_CTRL);
  assign lock_clr = reg_rd && (reg_addr == ADR_TIMER);
  assign irq      = |(flag_word & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      warn  <= 1'b0;
      ovf   <= 1'b0;
      mask  <= '0;
      timer <= '0;
    end else begin
      timer <= timer + 1'b1;
      if (warn_set)                          warn <= 1'b1;
      else if (flag_wr && reg_wdata[FLG_WARN]) warn <= 1'b0;
      if (ovf_set)                           ovf <= 1'b1;
      else if (flag_wr && reg_wdata[FLG_OVF])  ovf <= 1'b0;
      if (reg_wr && reg_addr == ADR_MASK) mask <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADR_CTRL:  reg_rdata <= win_valid ? win_frame.ctrl : '0;
        ADR_ID:    reg_rdata <= win_valid ? win_frame.id   : '0;
        ADR_D0:    reg_rdata <= win_valid ? win_frame.d0   : '0;
        ADR_D1:    reg_rdata <= win_valid ? win_frame.d1   : '0;
        ADR_FLAGS: reg_rdata <= flag_word;
        ADR_MASK:  reg_rdata <= mask;
        ADR_TIMER: reg_rdata <= WORD_W'(timer);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_OVF_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !reg_wdata[FLG_OVF] && ovf) |=> ovf); // R12
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf); // R12
  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mask[FLG_OVF:FLG_AVAIL] == 3'b000) |-> !irq); // R13
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (timer == TIMER_W'($past(timer) + 1'b1))); // R9
endmodule

// File: rtl/rxq_window.sv
module rxq_window import rxq_pkg::*; #(
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5,
  parameter int LOAD_CYC = 4,
  parameter int TIMER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_ctrl,
  input  logic [WORD_W-1:0] in_id,
  input  logic [WORD_W-1:0] in_d0,
  input  logic [WORD_W-1:0] in_d1,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  rxq_frame_t in_frame, head_q, win_frame;
  logic nonempty, warn_set, ovf_set, pop, lock_set, lock_clr, win_valid;

  assign in_frame = '{ctrl: in_ctrl, id: in_id, d0: in_d0, d1: in_d1};

  rxq_store #(.DEPTH(DEPTH), .WARN_LVL(WARN_LVL)) u_store (
    .clk(clk), .rst(rst), .push_valid(in_valid), .push_frame(in_frame),
    .pop(pop), .head_q(head_q), .nonempty(nonempty),
    .warn_set(warn_set), .ovf_set(ovf_set)
  );

  rxq_loader #(.LOAD_CYC(LOAD_CYC)) u_loader (
    .clk(clk), .rst(rst), .head_q(head_q), .nonempty(nonempty), .pop(pop),
    .lock_set(lock_set), .lock_clr(lock_clr),
    .win_frame(win_frame), .win_valid(win_valid)
  );

  rxq_regs #(.TIMER_W(TIMER_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .win_frame(win_frame), .win_valid(win_valid),
    .warn_set(warn_set), .ovf_set(ovf_set),
    .reg_rdata(reg_rdata), .irq(irq), .pop(pop),
    .lock_set(lock_set), .lock_clr(lock_clr)
  );
endmodule

// File: tb/rxq_window_bench.sv
`timescale 1ns/1ps
module rxq_window_bench;
  localparam int DEPTH = 6, WARN = 5, L = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [127:0] in_fr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #2.5 clk = ~clk;

  rxq_window u_rxq_window (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_ctrl(in_fr[127:96]), .in_id(in_fr[95:64]), .in_d0(in_fr[63:32]), .in_d1(in_fr[31:0]),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit started = 0, done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] fr(input int n);
    return {32'hC0DE_0000 + n, 32'h0000_1000 + n, 32'hDA7A_0000 + n, 32'h5EED_0000 + n};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [127:0] mq[$];
  logic [127:0] m_win;
  bit   m_wv, m_busy, m_lock, m_warn, m_ovf, m_rdv;
  int   m_cnt;
  logic [31:0] m_mask, m_rdata;
  logic [15:0] m_timer;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_wv ? m_win[127:96] : 32'h0;
      3'd1: return m_wv ? m_win[95:64]  : 32'h0;
      3'd2: return m_wv ? m_win[63:32]  : 32'h0;
      3'd3: return m_wv ? m_win[31:0]   : 32'h0;
      3'd4: return {24'h0, m_ovf, m_warn, m_wv, 5'h0};
      3'd5: return m_mask;
      3'd6: return {16'h0, m_timer};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_wv = 0; m_busy = 0; m_lock = 0; m_warn = 0; m_ovf = 0; m_rdv = 0;
      m_cnt = 0; m_mask = '0; m_rdata = '0; m_timer = '0; m_win = '0;
    end else begin
      int  osz;
      bit  owv, olock, pop, acc, fwr;
      osz = mq.size(); owv = m_wv; olock = m_lock;
      m_rdv = reg_rd;
      if (reg_rd) m_rdata = m_read(reg_addr);
      fwr = reg_wr && reg_addr == 3'd4;
      pop = fwr && reg_wdata[5] && m_wv;
      if (m_busy) begin
        if (m_cnt == 0) begin m_wv = 1; m_win = mq[0]; m_busy = 0; end
        else m_cnt--;
      end else if (pop) m_wv = 0;
      else if (!owv && osz > 0 && !olock) begin m_busy = 1; m_cnt = L - 1; end
      if (pop) void'(mq.pop_front());
      acc = in_valid && (osz < DEPTH || pop);
      if (acc) mq.push_back(in_fr);
      if (fwr && reg_wdata[6]) m_warn = 0;
      if (fwr && reg_wdata[7]) m_ovf = 0;
      if (acc && !pop && osz == WARN - 1) m_warn = 1;
      if (in_valid && !acc) m_ovf = 1;
      if (reg_wr && reg_addr == 3'd5) m_mask = reg_wdata;
      if (reg_rd && reg_addr == 3'd0) m_lock = 1;
      else if (reg_rd && reg_addr == 3'd6) m_lock = 0;
      m_timer = m_timer + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      check("R13 model irq", {31'h0, irq},
            {31'h0, |({m_ovf, m_warn, m_wv} & m_mask[7:5])});
      if (m_rdv) check("R2 model rdata", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [31:0] v;

  task automatic cyc(input bit iv, input logic [127:0] f, input bit w, input bit r,
                     input logic [2:0] a, input logic [31:0] d);
    in_valid = iv; in_fr = f; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    v = rdata;
    in_valid = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 3'd0, 0);
  endtask
  task automatic push(input int n);  cyc(1, fr(n), 0, 0, 3'd0, 0); endtask
  task automatic rd(input logic [2:0] a); cyc(0, '0, 0, 1, a, 0); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d); cyc(0, '0, 1, 0, a, d); endtask

  task automatic take(input int n, input string tag);
    logic [127:0] e;
    e = fr(n);
    rd(3'd0); check({tag, " ctrl"}, v, e[127:96]);
    rd(3'd3); check({tag, " d1"}, v, e[31:0]);
    wr(3'd4, 32'h20);
    rd(3'd6);
    idle(L + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] t1;
    repeat (3) @(negedge clk);
    rst = 0; started = 1;
    // R1 reset state
    rd(3'd4); check("R1 flags", v, 32'h0);
    rd(3'd0); check("R1 window ctrl", v, 32'h0);
    rd(3'd5); check("R1 mask", v, 32'h0);
    rd(3'd6);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(3'd7); check("R2 unused offset", v, 32'h0);
    // R13 mask, R6 arrival into empty queue
    wr(3'd5, 32'hA5A5_00E0);
    rd(3'd5); check("R13 mask readback", v, 32'hA5A5_00E0);
    push(1);
    idle(L);   check("R6 flag still low", {31'h0, irq}, 32'h0);
    idle(1);   check("R6 flag rises", {31'h0, irq}, 32'h1);
    rd(3'd4);  check("R3 flag word", v, 32'h20);
    wr(3'd5, 32'h0);  check("R13 masked irq", {31'h0, irq}, 32'h0);
    wr(3'd5, 32'hE0); check("R13 unmasked irq", {31'h0, irq}, 32'h1);
    // R4 writes that do nothing
    wr(3'd4, 32'h0);  rd(3'd4); check("R4 write zero", v, 32'h20);
    wr(3'd4, 32'h1F); rd(3'd4); check("R4 other bits", v, 32'h20);
    // R2 full window read
    rd(3'd0); check("R2 ctrl", v, 32'hC0DE_0001);
    rd(3'd1); check("R2 id", v, 32'h0000_1001);
    rd(3'd2); check("R2 d0", v, 32'hDA7A_0001);
    rd(3'd3); check("R2 d1", v, 32'h5EED_0001);
    wr(3'd4, 32'h20); rd(3'd6);
    rd(3'd4); check("R6 empty stays low", v, 32'h0);
    idle(8); rd(3'd4); check("R6 still low later", v, 32'h0);
    rd(3'd0); check("R2 empty window reads 0", v, 32'h0);
    rd(3'd6);
    wr(3'd4, 32'h20); rd(3'd4); check("R4 clear when clear", v, 32'h0);
    // R5 timing, R7 order, R8 lock
    push(2); push(3); push(4); idle(8);
    rd(3'd0); check("R7 first", v, 32'hC0DE_0002);
    rd(3'd6);
    wr(3'd4, 32'h20);
    idle(L);  check("R5 flag low while loading", {31'h0, irq}, 32'h0);
    idle(1);  check("R5 flag back", {31'h0, irq}, 32'h1);
    rd(3'd0); check("R7 second", v, 32'hC0DE_0003);
    wr(3'd4, 32'h20);
    idle(10); check("R8 locked no load", {31'h0, irq}, 32'h0);
    rd(3'd6);
    idle(L);  check("R8 load pending", {31'h0, irq}, 32'h0);
    idle(1);  check("R8 load after release", {31'h0, irq}, 32'h1);
    take(4, "R7 third");
    // R10 / R11 / R12
    for (int i = 10; i < 16; i++) push(i);
    idle(8);
    rd(3'd4); check("R11 warn set", v, 32'h60);
    push(16);
    rd(3'd4); check("R10 overflow set", v, 32'hE0);
    wr(3'd4, 32'hC0);
    rd(3'd4); check("R12 w1c", v, 32'h20);
    for (int i = 10; i < 16; i++) take(i, "R10 drain order");
    rd(3'd4); check("R10 dropped frame absent", v, 32'h0);
    // R14 simultaneous arrival and retire while full
    for (int i = 20; i < 26; i++) push(i);
    idle(8);
    cyc(1, fr(26), 1, 0, 3'd4, 32'h60);
    rd(3'd4); check("R14 no overflow", v, 32'h0);
    idle(L + 2);
    for (int i = 21; i < 27; i++) take(i, "R14 order");
    rd(3'd4); check("R14 drained", v, 32'h0);
    // R12 set wins over clear
    for (int i = 30; i < 36; i++) push(i);
    idle(8);
    push(36);
    cyc(1, fr(37), 1, 0, 3'd4, 32'h80);
    rd(3'd4); check("R12 set wins", v, 32'hE0);
    wr(3'd4, 32'hC0);
    for (int i = 30; i < 36; i++) take(i, "R12 drain");
    // R9 timer
    rd(3'd6); t1 = v;
    idle(2);
    rd(3'd6); check("R9 timer step", v - t1, 32'd3);
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule